// File: doc/BRIEF.md
# Two-Level Tiled 1-D Convolution Sequencer

This block steps a single multiply-accumulate unit through a 1-D "valid" convolution. The output length E and the filter length R are each factored into an outer (level-1) count and an inner (level-0) tile size. The block keeps three small tile register files: weights, inputs and partial sums. For each outer iteration it fills them from larger level-1 memories that sit outside the block. It then sweeps the tile with one MAC per cycle and writes the partial sums back to the level-1 output memory.

On every MAC cycle the block also presents the global output, weight and input indices. A host writes the four factors on the configuration pins and pulses `start`. The block latches the factors at that moment. If the tile would not fit the tile register files, the block refuses the job and raises an error flag instead of touching memory. The level-1 memories return read data one cycle after the read request.

Top module: `conv_tile_seq`

## Requirements
- R1: The MAC sequence runs with the outer output-tile counter outermost, then the outer filter counter, then the inner output counter, then the inner filter counter, which is innermost and changes fastest.
- R2: On each cycle with `mac_valid` high, `mac_o_idx` equals e1*E0+e0 and `mac_w_idx` equals r1*R0+r0.
- R3: On each cycle with `mac_valid` high, `mac_i_idx` equals e1*E0+e0+r1*R0+r0.
- R4: A start is refused when any factor is zero, when E0 exceeds the partial-sum tile depth (4), when R0 exceeds the weight tile depth (4), or when E0+R0-1 exceeds the input tile depth (6). A refused start sets `cfg_err`, pulses `done` in the next cycle and leaves `busy` low with no memory access and no MAC. `cfg_err` stays set until the next accepted start, which clears it.
- R5: After a run, level-1 output word e holds the sum over r of in[e+r]*w[r] for all e < E0*E1. Level-1 output contents from before the run have no effect.
- R6: Each tile ends with E0 writes to output addresses e1*E0 .. e1*E0+E0-1. Partial sums are read back from level 1 only for tiles with r1 > 0. A run therefore makes E1*R1*E0 writes and E1*(R1-1)*E0 output reads.
- R7: The factors are sampled on the accepted start. Later changes to the configuration pins during the run have no effect on indices or results.
- R8: `busy` is high from the cycle after an accepted start until the run ends. A `start` while busy is ignored. While `busy` is low, no memory request, write or MAC is issued.
- R9: `done` is a one-cycle pulse, high in the first cycle after the last write of a run, and `busy` is low whenever `done` is high.
- R10: After reset, `busy`, `done`, `cfg_err`, `mac_valid` and all memory enables are low.
- R11: A run issues exactly E0*E1*R0*R1 MAC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a run with the factors on the cfg pins |
| cfg_e0 | input | CNT_W | Inner output tile size E0 |
| cfg_e1 | input | CNT_W | Outer output tile count E1 |
| cfg_r0 | input | CNT_W | Inner filter tile size R0 |
| cfg_r1 | input | CNT_W | Outer filter tile count R1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start was refused |
| w1_rd_en | output | 1 | Level-1 weight read request |
| w1_rd_addr | output | IDX_W | Level-1 weight address |
| w1_rd_data | input | DW | Weight data, one cycle after request |
| i1_rd_en | output | 1 | Level-1 input read request |
| i1_rd_addr | output | IDX_W | Level-1 input address |
| i1_rd_data | input | DW | Input data, one cycle after request |
| o1_rd_en | output | 1 | Level-1 partial-sum read request |
| o1_rd_addr | output | IDX_W | Level-1 partial-sum read address |
| o1_rd_data | input | AW | Partial-sum data, one cycle after request |
| o1_wr_en | output | 1 | Level-1 partial-sum write |
| o1_wr_addr | output | IDX_W | Level-1 partial-sum write address |
| o1_wr_data | output | AW | Partial sum written back |
| mac_valid | output | 1 | A MAC is performed this cycle |
| mac_o_idx | output | IDX_W | Global output index of this MAC |
| mac_w_idx | output | IDX_W | Global weight index of this MAC |
| mac_i_idx | output | IDX_W | Global input index of this MAC |

## Verification
Several factorisations are run. A square 2x2x2x2 split exercises both reload and writeback. A single-tile split (E1=R1=1) never reloads, so it separates the zero-start path from the reload path. A degenerate split with tile size 1 and three outer iterations on each axis puts all the work in the outer counters. A split that fills the input tile exactly (E0=4, R0=3) exercises the capacity edge. The index scoreboard separates a wrong loop order from a wrong index formula. The final memory compare catches a missed reload or a missed zero start. Refused configurations cover each capacity limit and a zero factor. A run with a disturbed configuration and a repeated start shows that latching works and that the repeated start is ignored.

// File: rtl/cts_pkg.sv
package cts_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_LDWAIT,
      ST_MAC,
      ST_STORE
   } cts_state_e;
endpackage

// File: rtl/cts_loop_pair.sv
module cts_loop_pair #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] lim_out,
   input  logic [W-1:0] lim_in,
   output logic [W-1:0] idx_out,
   output logic [W-1:0] idx_in,
   output logic         last
);
   logic wrap_in;

   assign wrap_in = (idx_in == lim_in - W'(1));
   assign last    = wrap_in && (idx_out == lim_out - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_out <= '0;
         idx_in  <= '0;
      end else if (clr) begin
         idx_out <= '0;
         idx_in  <= '0;
      end else if (step) begin
         if (wrap_in) begin
            idx_in  <= '0;
            idx_out <= last ? '0 : idx_out + W'(1);
         end else begin
            idx_in <= idx_in + W'(1);
         end
      end
   end

   // R1: inner counter advances first, outer only on inner wrap
   p_inner_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !wrap_in) |=> (idx_in == $past(idx_in) + W'(1)) && $stable(idx_out));
endmodule

// File: rtl/cts_cfg_check.sv
module cts_cfg_check #(
   parameter int CNT_W    = 4,
   parameter int W0_DEPTH = 4,
   parameter int I0_DEPTH = 6,
   parameter int O0_DEPTH = 4
) (
   input  logic [CNT_W-1:0] e0,
   input  logic [CNT_W-1:0] e1,
   input  logic [CNT_W-1:0] r0,
   input  logic [CNT_W-1:0] r1,
   output logic             fits
);
   if (W0_DEPTH < 1 || O0_DEPTH < 1) begin : g_bad_depth
      $error("tile depths must be at least one");
   end
   if (I0_DEPTH < W0_DEPTH && I0_DEPTH < O0_DEPTH) begin : g_bad_in
      $error("input tile smaller than both other tiles");
   end
   if (O0_DEPTH >= (1 << CNT_W) || W0_DEPTH >= (1 << CNT_W)) begin : g_bad_cnt
      $error("counter width too small for tile depths");
   end

   logic nonzero;
   logic in_cap;
   assign nonzero = (e0 != '0) && (e1 != '0) && (r0 != '0) && (r1 != '0);
   assign in_cap  = (int'(e0) + int'(r0)) <= (I0_DEPTH + 1);
   assign fits    = nonzero && in_cap &&
                    (int'(e0) <= O0_DEPTH) && (int'(r0) <= W0_DEPTH);
endmodule

// File: rtl/cts_l0_buf.sv
module cts_l0_buf #(
   parameter int DEPTH  = 4,
   parameter int DW     = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DW-1:0]     rdata
);
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("address too narrow for depth");
   end

   logic [DW-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && (waddr == ADDR_W'(g))) slot[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (raddr == ADDR_W'(k)) rdata = slot[k];
      end
   end

   // R4: a legal configuration never addresses beyond the tile
   p_tile_write_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/conv_tile_seq.sv
module conv_tile_seq #(
   parameter int CNT_W    = 4,
   parameter int IDX_W    = 10,
   parameter int DW       = 8,
   parameter int AW       = 24,
   parameter int W0_DEPTH = 4,
   parameter int I0_DEPTH = 6,
   parameter int O0_DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cfg_e0,
   input  logic [CNT_W-1:0] cfg_e1,
   input  logic [CNT_W-1:0] cfg_r0,
   input  logic [CNT_W-1:0] cfg_r1,
   output logic             busy,
   output logic             done,
   output logic             cfg_err,
   output logic             w1_rd_en,
   output logic [IDX_W-1:0] w1_rd_addr,
   input  logic [DW-1:0]    w1_rd_data,
   output logic             i1_rd_en,
   output logic [IDX_W-1:0] i1_rd_addr,
   input  logic [DW-1:0]    i1_rd_data,
   output logic             o1_rd_en,
   output logic [IDX_W-1:0] o1_rd_addr,
   input  logic [AW-1:0]    o1_rd_data,
   output logic             o1_wr_en,
   output logic [IDX_W-1:0] o1_wr_addr,
   output logic [AW-1:0]    o1_wr_data,
   output logic             mac_valid,
   output logic [IDX_W-1:0] mac_o_idx,
   output logic [IDX_W-1:0] mac_w_idx,
   output logic [IDX_W-1:0] mac_i_idx
);
   import cts_pkg::*;

   localparam int LW     = CNT_W + 1;
   localparam int PROD_W = 2 * DW;

   if (IDX_W < 2 * CNT_W + 1) begin : g_bad_idx
      $error("index width cannot hold the largest index");
   end
   if (AW < PROD_W) begin : g_bad_acc
      $error("accumulator narrower than a product");
   end

   cts_state_e        state;
   logic [CNT_W-1:0]  c_e0, c_e1, c_r0, c_r1;
   logic              cfg_fits;
   logic [CNT_W-1:0]  e1, r1, e0, r0;
   logic              l1_last, l0_last;
   logic              l1_clr, l1_step, l0_clr, l0_step;
   logic [LW-1:0]     ld_k, ld_len;
   logic [CNT_W-1:0]  st_k;
   logic              done_q, err_q;
   logic              pd_v, pd_w, pd_o, pd_zero;
   logic [LW-1:0]     pd_k;
   logic [IDX_W-1:0]  base_o, base_w;
   logic [DW-1:0]     w_tile, i_tile;
   logic [AW-1:0]     acc_rd, acc_wdata, mac_sum;
   logic [LW-1:0]     acc_waddr, acc_raddr, w_raddr, i_raddr;
   logic              acc_we;
   logic [PROD_W-1:0] product;

   cts_cfg_check #(
      .CNT_W(CNT_W), .W0_DEPTH(W0_DEPTH), .I0_DEPTH(I0_DEPTH), .O0_DEPTH(O0_DEPTH)
   ) u_check (
      .e0(cfg_e0), .e1(cfg_e1), .r0(cfg_r0), .r1(cfg_r1), .fits(cfg_fits)
   );

   cts_loop_pair #(.W(CNT_W)) u_l1 (
      .clk(clk), .rst_n(rst_n), .clr(l1_clr), .step(l1_step),
      .lim_out(c_e1), .lim_in(c_r1), .idx_out(e1), .idx_in(r1), .last(l1_last)
   );

   cts_loop_pair #(.W(CNT_W)) u_l0 (
      .clk(clk), .rst_n(rst_n), .clr(l0_clr), .step(l0_step),
      .lim_out(c_e0), .lim_in(c_r0), .idx_out(e0), .idx_in(r0), .last(l0_last)
   );

   assign base_o = IDX_W'(e1) * IDX_W'(c_e0);
   assign base_w = IDX_W'(r1) * IDX_W'(c_r0);
   assign ld_len = LW'(c_e0) + LW'(c_r0) - LW'(1);

   assign busy      = (state != ST_IDLE);
   assign done      = done_q;
   assign cfg_err   = err_q;
   assign mac_valid = (state == ST_MAC);

   assign l1_clr  = (state == ST_IDLE) && start;
   assign l1_step = (state == ST_STORE) && (st_k == c_e0 - CNT_W'(1)) && !l1_last;
   assign l0_clr  = (state == ST_LDWAIT);
   assign l0_step = mac_valid;

   // level-1 read requests during the tile fill
   assign i1_rd_en   = (state == ST_LOAD);
   assign i1_rd_addr = base_o + base_w + IDX_W'(ld_k);
   assign w1_rd_en   = (state == ST_LOAD) && (ld_k < LW'(c_r0));
   assign w1_rd_addr = base_w + IDX_W'(ld_k);
   assign o1_rd_en   = (state == ST_LOAD) && (ld_k < LW'(c_e0)) && (r1 != '0);
   assign o1_rd_addr = base_o + IDX_W'(ld_k);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_v    <= 1'b0;
         pd_w    <= 1'b0;
         pd_o    <= 1'b0;
         pd_zero <= 1'b0;
         pd_k    <= '0;
      end else begin
         pd_v    <= (state == ST_LOAD);
         pd_w    <= w1_rd_en;
         pd_o    <= (state == ST_LOAD) && (ld_k < LW'(c_e0));
         pd_zero <= (r1 == '0);
         pd_k    <= ld_k;
      end
   end

   // tile register files
   assign w_raddr = LW'(r0);
   assign i_raddr = LW'(e0) + LW'(r0);

   cts_l0_buf #(.DEPTH(W0_DEPTH), .DW(DW), .ADDR_W(LW)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .we(pd_v && pd_w), .waddr(pd_k), .wdata(w1_rd_data),
      .raddr(w_raddr), .rdata(w_tile)
   );

   cts_l0_buf #(.DEPTH(I0_DEPTH), .DW(DW), .ADDR_W(LW)) u_ibuf (
      .clk(clk), .rst_n(rst_n), .we(pd_v), .waddr(pd_k), .wdata(i1_rd_data),
      .raddr(i_raddr), .rdata(i_tile)
   );

   assign product   = PROD_W'(w_tile) * PROD_W'(i_tile);
   assign mac_sum   = acc_rd + AW'(product);
   assign acc_we    = (pd_v && pd_o) || mac_valid;
   assign acc_waddr = mac_valid ? LW'(e0) : pd_k;
   assign acc_wdata = mac_valid ? mac_sum : (pd_zero ? '0 : o1_rd_data);
   assign acc_raddr = (state == ST_STORE) ? LW'(st_k) : LW'(e0);

   cts_l0_buf #(.DEPTH(O0_DEPTH), .DW(AW), .ADDR_W(LW)) u_abuf (
      .clk(clk), .rst_n(rst_n), .we(acc_we), .waddr(acc_waddr), .wdata(acc_wdata),
      .raddr(acc_raddr), .rdata(acc_rd)
   );

   assign mac_o_idx = base_o + IDX_W'(e0);
   assign mac_w_idx = base_w + IDX_W'(r0);
   assign mac_i_idx = base_o + base_w + IDX_W'(e0) + IDX_W'(r0);

   assign o1_wr_en   = (state == ST_STORE);
   assign o1_wr_addr = base_o + IDX_W'(st_k);
   assign o1_wr_data = acc_rd;

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         c_e0   <= '0;
         c_e1   <= '0;
         c_r0   <= '0;
         c_r1   <= '0;
         ld_k   <= '0;
         st_k   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  c_e0 <= cfg_e0;
                  c_e1 <= cfg_e1;
                  c_r0 <= cfg_r0;
                  c_r1 <= cfg_r1;
                  ld_k <= '0;
                  if (cfg_fits) begin
                     err_q <= 1'b0;
                     state <= ST_LOAD;
                  end else begin
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                  end
               end
            end
            ST_LOAD: begin
               ld_k <= ld_k + LW'(1);
               if (ld_k == ld_len - LW'(1)) state <= ST_LDWAIT;
            end
            ST_LDWAIT: state <= ST_MAC;
            ST_MAC: begin
               if (l0_last) begin
                  st_k  <= '0;
                  state <= ST_STORE;
               end
            end
            ST_STORE: begin
               st_k <= st_k + CNT_W'(1);
               if (st_k == c_e0 - CNT_W'(1)) begin
                  ld_k <= '0;
                  if (l1_last) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     state <= ST_LOAD;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4: a refused configuration never starts a run
   p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !busy);
   // R8: nothing is requested or computed while idle
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mac_valid || o1_wr_en || o1_rd_en || i1_rd_en || w1_rd_en));
   // R9: the end pulse never overlaps a run
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R7: latched factors hold for the whole run
   p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable({c_e0, c_e1, c_r0, c_r1}));
   // R2: weight index stays inside the filter
   p_w_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mac_valid |-> (int'(mac_w_idx) < int'(c_r0) * int'(c_r1)));
   // R6: writeback stays inside the output vector
   p_wb_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      o1_wr_en |-> (int'(o1_wr_addr) < int'(c_e0) * int'(c_e1)));
endmodule

// File: tb/tb_conv_tile_seq.sv
module tb_conv_tile_seq;
   localparam int CNT_W = 4;
   localparam int IDX_W = 10;
   localparam int DW    = 8;
   localparam int AW    = 24;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] cfg_e0 = '0, cfg_e1 = '0, cfg_r0 = '0, cfg_r1 = '0;
   logic             busy, done, cfg_err;
   logic             w1_rd_en, i1_rd_en, o1_rd_en, o1_wr_en, mac_valid;
   logic [IDX_W-1:0] w1_rd_addr, i1_rd_addr, o1_rd_addr, o1_wr_addr;
   logic [IDX_W-1:0] mac_o_idx, mac_w_idx, mac_i_idx;
   logic [DW-1:0]    w1_rd_data, i1_rd_data;
   logic [AW-1:0]    o1_rd_data, o1_wr_data;

   always #4 clk = ~clk;

   conv_tile_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_e0(cfg_e0), .cfg_e1(cfg_e1), .cfg_r0(cfg_r0), .cfg_r1(cfg_r1),
      .busy(busy), .done(done), .cfg_err(cfg_err),
      .w1_rd_en(w1_rd_en), .w1_rd_addr(w1_rd_addr), .w1_rd_data(w1_rd_data),
      .i1_rd_en(i1_rd_en), .i1_rd_addr(i1_rd_addr), .i1_rd_data(i1_rd_data),
      .o1_rd_en(o1_rd_en), .o1_rd_addr(o1_rd_addr), .o1_rd_data(o1_rd_data),
      .o1_wr_en(o1_wr_en), .o1_wr_addr(o1_wr_addr), .o1_wr_data(o1_wr_data),
      .mac_valid(mac_valid), .mac_o_idx(mac_o_idx), .mac_w_idx(mac_w_idx),
      .mac_i_idx(mac_i_idx)
   );

   // level-1 memory models, one-cycle read latency
   logic [DW-1:0] wmem [0:1023];
   logic [DW-1:0] imem [0:1023];
   logic [AW-1:0] omem [0:1023];
   int n_owr = 0, n_ord = 0, n_mac = 0, n_any = 0;

   always @(posedge clk) begin
      if (w1_rd_en) w1_rd_data <= wmem[w1_rd_addr];
      if (i1_rd_en) i1_rd_data <= imem[i1_rd_addr];
      if (o1_rd_en) begin o1_rd_data <= omem[o1_rd_addr]; n_ord <= n_ord + 1; end
      if (o1_wr_en) begin omem[o1_wr_addr] <= o1_wr_data; n_owr <= n_owr + 1; end
      if (mac_valid) n_mac <= n_mac + 1;
      if (w1_rd_en || i1_rd_en || o1_rd_en || o1_wr_en || mac_valid) n_any <= n_any + 1;
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard of expected MAC index triples
   logic [3*IDX_W-1:0] exp_q[$];

   always @(negedge clk) begin
      if (rst_n && mac_valid) begin
         if (exp_q.size() == 0) begin
            check(0, "R11 extra MAC", n_mac, 0);
         end else begin
            logic [3*IDX_W-1:0] e;
            e = exp_q.pop_front();
            // R1 ordering is implied by the queue order
            check(mac_o_idx == e[3*IDX_W-1:2*IDX_W], "R1/R2 output index",
                  mac_o_idx, e[3*IDX_W-1:2*IDX_W]);
            check(mac_w_idx == e[2*IDX_W-1:IDX_W], "R1/R2 weight index",
                  mac_w_idx, e[2*IDX_W-1:IDX_W]);
            check(mac_i_idx == e[IDX_W-1:0], "R3 input index", mac_i_idx, e[IDX_W-1:0]);
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_case(input int e0, input int e1, input int r0, input int r1,
                           input int seed, input bit disturb);
      int ee, rr, h, wr0, rd0, mac0, lim;
      longint ref_o;
      ee = e0 * e1; rr = r0 * r1; h = ee + rr - 1;
      for (int k = 0; k < 1024; k++) begin
         wmem[k] = DW'((k * 3 + seed) & 255);
         imem[k] = DW'((k * 7 + 2 * seed + 1) & 255);
         omem[k] = AW'(24'h5A5A5A);
      end
      for (int a = 0; a < e1; a++)
         for (int b = 0; b < r1; b++)
            for (int c = 0; c < e0; c++)
               for (int d = 0; d < r0; d++)
                  exp_q.push_back({IDX_W'(a * e0 + c), IDX_W'(b * r0 + d),
                                   IDX_W'(a * e0 + c + b * r0 + d)});
      wr0 = n_owr; rd0 = n_ord; mac0 = n_mac;
      @(negedge clk);
      cfg_e0 = CNT_W'(e0); cfg_e1 = CNT_W'(e1); cfg_r0 = CNT_W'(r0); cfg_r1 = CNT_W'(r1);
      pulse_start();
      check(busy == 1'b1, "R8 busy after start", busy, 1);
      check(cfg_err == 1'b0, "R4 error clear on accept", cfg_err, 0);
      if (disturb) begin
         // R7/R8: new config and a second start during the run
         cfg_e0 = 4'd1; cfg_e1 = 4'd1; cfg_r0 = 4'd1; cfg_r1 = 4'd1;
         pulse_start();
         cfg_e0 = 4'd7; cfg_r1 = 4'd9;
      end
      lim = 0;
      while (!done && lim < 5000) begin @(negedge clk); lim++; end
      check(done == 1'b1, "R9 done seen", done, 1);
      check(busy == 1'b0, "R9 busy low with done", busy, 0);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle", done, 0);
      check(exp_q.size() == 0, "R1 all MACs seen", exp_q.size(), 0);
      exp_q.delete();
      check(n_mac - mac0 == ee * rr, "R11 MAC count", n_mac - mac0, ee * rr);
      check(n_owr - wr0 == ee * r1, "R6 writeback count", n_owr - wr0, ee * r1);
      check(n_ord - rd0 == ee * (r1 - 1), "R6 reload count", n_ord - rd0, ee * (r1 - 1));
      for (int e = 0; e < ee; e++) begin
         ref_o = 0;
         for (int r = 0; r < rr; r++) ref_o += longint'(imem[e + r]) * longint'(wmem[r]);
         check(omem[e] == AW'(ref_o), disturb ? "R7 result with latched config" : "R5 result",
               omem[e], ref_o);
      end
      check(omem[ee] == AW'(24'h5A5A5A), "R6 no write past output", omem[ee], 24'h5A5A5A);
      if (h > 1023) check(0, "bench range", h, 1023);
   endtask

   task automatic bad_case(input int e0, input int e1, input int r0, input int r1,
                           input string tag);
      int any0;
      any0 = n_any;
      @(negedge clk);
      cfg_e0 = CNT_W'(e0); cfg_e1 = CNT_W'(e1); cfg_r0 = CNT_W'(r0); cfg_r1 = CNT_W'(r1);
      pulse_start();
      check(done == 1'b1, {tag, " done pulse"}, done, 1);
      check(cfg_err == 1'b1, {tag, " error set"}, cfg_err, 1);
      check(busy == 1'b0, {tag, " stays idle"}, busy, 0);
      repeat (6) @(negedge clk);
      check(n_any == any0, {tag, " no access"}, n_any - any0, 0);
      check(cfg_err == 1'b1, {tag, " error held"}, cfg_err, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset values
      check(busy == 0, "R10 busy", busy, 0);
      check(done == 0, "R10 done", done, 0);
      check(cfg_err == 0, "R10 cfg_err", cfg_err, 0);
      check({mac_valid, o1_wr_en, o1_rd_en, i1_rd_en, w1_rd_en} == 0, "R10 enables",
            {mac_valid, o1_wr_en, o1_rd_en, i1_rd_en, w1_rd_en}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_case(2, 2, 2, 2, 5, 0);
      run_case(3, 1, 4, 1, 9, 0);
      run_case(1, 3, 1, 3, 2, 0);
      run_case(4, 2, 3, 2, 11, 0);
      bad_case(5, 1, 1, 1, "R4 E0 over depth");
      bad_case(4, 1, 4, 1, "R4 input tile over depth");
      run_case(2, 1, 2, 1, 1, 0);
      bad_case(1, 1, 5, 1, "R4 R0 over depth");
      bad_case(2, 0, 2, 1, "R4 zero factor");
      run_case(2, 3, 2, 2, 7, 1);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule